// File: doc/BRIEF.md
# Instruction Stream Cache Compressor

This block watches a stream of committed program-counter values and cuts it into instruction streams. A stream is a run of consecutive instruction addresses: it begins at the first address after a non-sequential step and ends at the next non-sequential step, or earlier, once it has grown to a configured maximum length. Each finished stream is summarised by a descriptor made of its start address and its length in instructions.

Descriptors are queued in a small buffer and looked up, one at a time and in arrival order, in a set-associative stream cache. On a hit the block emits a short index made of the set and the way. On a miss it emits the reserved index zero together with the full descriptor, and it installs the descriptor in the cache. Since index zero means a miss, the slot at set 0, way 0 is never filled. A hit takes one lookup cycle and a miss takes two, so the queue absorbs short bursts of new streams.

Top module: `stream_cache_comp`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, idx_valid_o and miss_valid_o are 0.
- R2: When a valid PC minus the previous valid PC (modulo 2^PC_W) is not 4, the stream being built closes with descriptor (start, length). The new stream starts at the current PC with length 1. Otherwise the length grows by one. The first PC after reset only opens a stream.
- R3: A stream whose length has reached MAX_LEN closes at the next valid PC even when that PC is sequential, so no descriptor length exceeds MAX_LEN.
- R4: The set of a descriptor is (start >> 2) XOR length, keeping the low log2(SETS) bits.
- R5: On a hit, idx_o = set * WAYS + way: the set sits in the upper bits and the way in the low log2(WAYS) bits.
- R6: On a miss, idx_o = 0 and miss_valid_o = 1 in the same cycle as idx_valid_o, with miss_start_o and miss_len_o carrying the descriptor, and the descriptor is installed in the cache.
- R7: Set 0, way 0 is never filled, so a hit never yields index 0.
- R8: The way filled on a miss is the lowest-numbered invalid way the set may use. If there is none, it is the least recently used of those ways. Both hits and fills make the way most recently used.
- R9: Every closed stream yields exactly one output, in order, and none is lost while at most one valid PC arrives in any two cycles.
- R10: Two misses are never reported in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_valid_i | input | 1 | A committed PC is present |
| pc_i | input | PC_W | Committed PC |
| idx_valid_o | output | 1 | An index is emitted this cycle |
| idx_o | output | log2(SETS)+log2(WAYS) | Cache index; 0 marks a miss |
| miss_valid_o | output | 1 | A miss descriptor is emitted this cycle |
| miss_start_o | output | PC_W | Start address of the missed stream |
| miss_len_o | output | LEN_W | Length of the missed stream |

## Verification
The assertions assume the descriptor queue is never pushed while it is full. That holds only when valid PCs arrive at most once every two cycles, because a miss keeps the lookup busy for two cycles. The stimulus keeps to that: every valid PC is followed by an idle cycle. It mixes loops that hit, a long straight run, a pool of streams that forces evictions, and streams that all hash to set 0. Each output is compared against a behavioural model of the splitting, hashing and least-recently-used rules.

// File: rtl/stream_cache_pkg.sv
package stream_cache_pkg;
  typedef enum logic [0:0] {LK_LOOK = 1'b0, LK_FILL = 1'b1} lk_state_e;
endpackage

// File: rtl/stream_detect.sv
module stream_detect #(
  parameter int PC_W    = 32,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pc_valid_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             push_o,
  output logic [PC_W-1:0]  start_o,
  output logic [LEN_W-1:0] len_o
);
  logic             have_q;
  logic [PC_W-1:0]  ppc_q, start_q;
  logic [LEN_W-1:0] len_q;
  logic             brk;

  assign brk     = ((pc_i - ppc_q) != PC_W'(4)) || (len_q == LEN_W'(MAX_LEN));
  assign push_o  = pc_valid_i && have_q && brk;
  assign start_o = start_q;
  assign len_o   = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      ppc_q   <= '0;
      start_q <= '0;
      len_q   <= '0;
    end else if (pc_valid_i) begin
      have_q <= 1'b1;
      ppc_q  <= pc_i;
      if (!have_q || brk) begin
        start_q <= pc_i;
        len_q   <= LEN_W'(1);
      end else begin
        len_q <= len_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/desc_fifo.sv
module desc_fifo #(
  parameter int W     = 37,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end
endmodule

// File: rtl/stream_lookup.sv
module stream_lookup
  import stream_cache_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int LEN_W = 5,
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_vld_i,
  input  logic [PC_W-1:0]  req_start_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_pop_o,
  output logic             idx_valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             miss_valid_o,
  output logic [PC_W-1:0]  miss_start_o,
  output logic [LEN_W-1:0] miss_len_o
);
  logic             v_q   [SETS][WAYS];
  logic [PC_W-1:0]  st_q  [SETS][WAYS];
  logic [LEN_W-1:0] ln_q  [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  logic             lk_vld_q;
  lk_state_e        state_q;
  logic [PC_W-1:0]  lk_start_q;
  logic [LEN_W-1:0] lk_len_q;
  logic [WAY_W-1:0] vic_q;

  logic [SET_W-1:0] set_idx;
  logic [WAYS-1:0]  hit_w;
  logic             hit, look, touch_en;
  logic [WAY_W-1:0] hit_way, vic_way, touch_way, vic_inv, vic_old, best_age;
  logic             have_inv;

  // set hash: address bits above the byte offset folded with the length
  assign set_idx = lk_start_q[2 +: SET_W] ^ SET_W'(lk_len_q);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_w[w] = v_q[set_idx][w] && (st_q[set_idx][w] == lk_start_q)
                      && (ln_q[set_idx][w] == lk_len_q);
  end

  assign hit = |hit_w;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_w[w]) hit_way = WAY_W'(w);
  end

  // set 0 / way 0 stays empty: index 0 encodes a miss
  always_comb begin
    vic_inv  = '0;
    have_inv = 1'b0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!(set_idx == '0 && w == 0) && !v_q[set_idx][w]) begin
        vic_inv  = WAY_W'(w);
        have_inv = 1'b1;
      end
    end
    vic_old  = (set_idx == '0) ? WAY_W'(1) : '0;
    best_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!(set_idx == '0 && w == 0) && age_q[set_idx][w] >= best_age) begin
        best_age = age_q[set_idx][w];
        vic_old  = WAY_W'(w);
      end
    end
    vic_way = have_inv ? vic_inv : vic_old;
  end

  assign look      = lk_vld_q && (state_q == LK_LOOK);
  assign touch_en  = (look && hit) || (lk_vld_q && state_q == LK_FILL);
  assign touch_way = (state_q == LK_FILL) ? vic_q : hit_way;
  assign req_pop_o = req_vld_i && (!lk_vld_q || touch_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_vld_q     <= 1'b0;
      state_q      <= LK_LOOK;
      lk_start_q   <= '0;
      lk_len_q     <= '0;
      vic_q        <= '0;
      idx_valid_o  <= 1'b0;
      idx_o        <= '0;
      miss_valid_o <= 1'b0;
      miss_start_o <= '0;
      miss_len_o   <= '0;
    end else begin
      if (req_pop_o) begin
        lk_vld_q   <= 1'b1;
        lk_start_q <= req_start_i;
        lk_len_q   <= req_len_i;
      end else if (touch_en) begin
        lk_vld_q <= 1'b0;
      end
      if (look && !hit) begin
        state_q <= LK_FILL;
        vic_q   <= vic_way;
      end else if (state_q == LK_FILL) begin
        state_q <= LK_LOOK;
      end
      idx_valid_o  <= touch_en;
      idx_o        <= (state_q == LK_FILL) ? '0 : {set_idx, hit_way};
      miss_valid_o <= lk_vld_q && (state_q == LK_FILL);
      miss_start_o <= lk_start_q;
      miss_len_o   <= lk_len_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          v_q[s][w]   <= 1'b0;
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_en) begin
      if (state_q == LK_FILL) v_q[set_idx][vic_q] <= 1'b1;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[set_idx][w] <= '0;
        else if (age_q[set_idx][w] < age_q[set_idx][touch_way])
          age_q[set_idx][w] <= age_q[set_idx][w] + WAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (lk_vld_q && state_q == LK_FILL) begin
      st_q[set_idx][vic_q] <= lk_start_q;
      ln_q[set_idx][vic_q] <= lk_len_q;
    end
  end
endmodule

// File: rtl/stream_cache_comp.sv
module stream_cache_comp #(
  parameter int PC_W    = 32,
  parameter int MAX_LEN = 16,
  parameter int SETS    = 8,
  parameter int WAYS    = 4,
  parameter int DEPTH   = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(SETS) + $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pc_valid_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             idx_valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             miss_valid_o,
  output logic [PC_W-1:0]  miss_start_o,
  output logic [LEN_W-1:0] miss_len_o
);
  localparam int DW = PC_W + LEN_W;

  logic             det_push, q_full, q_empty, q_pop;
  logic [PC_W-1:0]  det_start;
  logic [LEN_W-1:0] det_len;
  logic [DW-1:0]    q_rdata;

  stream_detect #(.PC_W(PC_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_det (
    .clk_i, .rst_ni, .pc_valid_i, .pc_i,
    .push_o(det_push), .start_o(det_start), .len_o(det_len)
  );

  desc_fifo #(.W(DW), .DEPTH(DEPTH)) u_q (
    .clk_i, .rst_ni,
    .push_i(det_push), .wdata_i({det_start, det_len}),
    .pop_i(q_pop), .rdata_o(q_rdata),
    .full_o(q_full), .empty_o(q_empty)
  );

  stream_lookup #(.PC_W(PC_W), .LEN_W(LEN_W), .SETS(SETS), .WAYS(WAYS)) u_lk (
    .clk_i, .rst_ni,
    .req_vld_i(!q_empty),
    .req_start_i(q_rdata[DW-1 -: PC_W]),
    .req_len_i(q_rdata[LEN_W-1:0]),
    .req_pop_o(q_pop),
    .idx_valid_o, .idx_o, .miss_valid_o, .miss_start_o, .miss_len_o
  );
endmodule

// File: rtl/stream_cache_comp_chk.sv
module stream_cache_comp_chk #(
  parameter int IDX_W   = 5,
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             full_i,
  input logic             idx_valid_i,
  input logic [IDX_W-1:0] idx_i,
  input logic             miss_valid_i,
  input logic [LEN_W-1:0] miss_len_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!idx_valid_i && !miss_valid_i);
  end

  assert_hit_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_valid_i && !miss_valid_i) |-> (idx_i != '0));

  assert_miss_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |-> (idx_valid_i && idx_i == '0));

  assert_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |-> (miss_len_i >= LEN_W'(1) && miss_len_i <= LEN_W'(MAX_LEN)));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_i));

  assert_miss_spacing_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |=> !miss_valid_i);
endmodule

bind stream_cache_comp stream_cache_comp_chk #(
  .IDX_W(IDX_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .push_i(det_push), .full_i(q_full),
  .idx_valid_i(idx_valid_o), .idx_i(idx_o),
  .miss_valid_i(miss_valid_o), .miss_len_i(miss_len_o)
);

// File: tb/stream_cache_comp_tb.sv
module stream_cache_comp_tb;
  localparam int PC_W = 32, MAX_LEN = 16, SETS = 8, WAYS = 4, DEPTH = 4;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int IDX_W = $clog2(SETS) + $clog2(WAYS);

  logic clk = 0, rst_ni = 0, pc_valid_i = 0;
  logic [PC_W-1:0] pc_i = '0;
  logic idx_valid_o, miss_valid_o;
  logic [IDX_W-1:0] idx_o;
  logic [PC_W-1:0] miss_start_o;
  logic [LEN_W-1:0] miss_len_o;

  always #4 clk = ~clk;

  stream_cache_comp #(.PC_W(PC_W), .MAX_LEN(MAX_LEN), .SETS(SETS), .WAYS(WAYS),
                      .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni, .pc_valid_i, .pc_i, .idx_valid_o, .idx_o,
    .miss_valid_o, .miss_start_o, .miss_len_o);

  int checks = 0, bad = 0, max_len_miss = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit have = 0;
  logic [31:0] ppc, cur_st;
  int cur_ln;
  bit m_v [SETS][WAYS];
  logic [31:0] m_st [SETS][WAYS];
  int m_ln [SETS][WAYS];
  int mru [SETS][$];
  int e_idx[$]; bit e_miss[$]; logic [31:0] e_st[$]; int e_ln[$];

  task automatic touch(int s, int w);
    for (int i = 0; i < mru[s].size(); i++)
      if (mru[s][i] == w) begin mru[s].delete(i); break; end
    mru[s].push_front(w);
  endtask

  task automatic model_desc(logic [31:0] st, int ln);
    int s, hw, vw;
    s = int'(((st >> 2) ^ ln) & (SETS - 1));
    hw = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_v[s][w] && m_st[s][w] == st && m_ln[s][w] == ln) hw = w;
    if (hw >= 0) begin
      e_idx.push_back(s * WAYS + hw); e_miss.push_back(0);
      e_st.push_back(st); e_ln.push_back(ln);
      touch(s, hw);
    end else begin
      vw = -1;
      for (int w = 0; w < WAYS; w++)
        if (vw < 0 && !(s == 0 && w == 0) && !m_v[s][w]) vw = w;
      if (vw < 0)
        for (int i = mru[s].size() - 1; i >= 0; i--)
          if (vw < 0 && !(s == 0 && mru[s][i] == 0)) vw = mru[s][i];
      m_v[s][vw] = 1; m_st[s][vw] = st; m_ln[s][vw] = ln;
      e_idx.push_back(0); e_miss.push_back(1);
      e_st.push_back(st); e_ln.push_back(ln);
      touch(s, vw);
    end
  endtask

  task automatic model_pc(logic [31:0] pc);
    if (!have) begin have = 1; cur_st = pc; cur_ln = 1; end
    else if (pc - ppc != 32'd4 || cur_ln == MAX_LEN) begin
      model_desc(cur_st, cur_ln); cur_st = pc; cur_ln = 1;
    end else cur_ln++;
    ppc = pc;
  endtask

  task automatic send(logic [31:0] pc);
    @(negedge clk); pc_valid_i = 1; pc_i = pc; model_pc(pc);
    @(negedge clk); pc_valid_i = 0;
  endtask

  task automatic run(logic [31:0] st, int n);
    for (int i = 0; i < n; i++) send(st + 32'(4 * i));
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin bad++; $display("FAIL %s act=%0d exp=%0d", req, act, exp); end
  endtask

  // output monitor, sampled away from the active edge
  bit prev_miss = 0;
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (idx_valid_o) begin
        if (e_idx.size() == 0) chk(0, "R9 unexpected output", int'(idx_o), -1);
        else begin
          if (e_miss[0]) begin
            chk(miss_valid_o && idx_o == 0, "R6 miss index", int'(idx_o), 0);
            chk(miss_start_o == e_st[0], "R2 miss start", int'(miss_start_o), int'(e_st[0]));
            chk(int'(miss_len_o) == e_ln[0], "R2 miss length", int'(miss_len_o), e_ln[0]);
            if (e_ln[0] == MAX_LEN) max_len_miss++;
          end else begin
            chk(!miss_valid_o && int'(idx_o) == e_idx[0], "R4/R5/R8 hit index",
                int'(idx_o), e_idx[0]);
            chk(idx_o != 0, "R7 hit index nonzero", int'(idx_o), 1);
          end
          void'(e_idx.pop_front()); void'(e_miss.pop_front());
          void'(e_st.pop_front()); void'(e_ln.pop_front());
        end
      end
      chk(!(prev_miss && miss_valid_o), "R10 miss spacing", int'(miss_valid_o), 0);
      prev_miss = miss_valid_o;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin
      m_v[s][w] = 0; mru[s].push_back(w);
    end
    repeat (3) @(negedge clk);
    chk(!idx_valid_o && !miss_valid_o, "R1 in reset", int'(idx_valid_o), 0);
    rst_ni = 1;
    @(negedge clk);
    chk(!idx_valid_o && !miss_valid_o, "R1 after reset", int'(idx_valid_o), 0);
    // loop of three streams: misses, then hits
    for (int k = 0; k < 10; k++) begin
      run(32'h1000, 5); run(32'h2040, 3); run(32'h3100, 7);
    end
    // long straight run splits at MAX_LEN (R3)
    run(32'h8000, 40);
    // pool of streams forcing evictions and LRU order (R8)
    for (int i = 0; i < 200; i++) begin
      int p = (i * 7 + i / 5) % 24;
      run(32'h4000 + 32'(p * 64 + (p % 8) * 4), 1 + (p % 5));
    end
    // streams that all map to set 0 (R7): addr bits [4:2]=0, length 8
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 5; j++) run(32'h10000 + 32'(j * 32'h100), 8);
    send(32'hF000);
    repeat (30) @(negedge clk);
    chk(e_idx.size() == 0, "R9 all streams reported", e_idx.size(), 0);
    chk(max_len_miss >= 2, "R3 max length streams", max_len_miss, 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; checks++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule